// File: doc/BRIEF.md
# DMA Channel Control and Status Registers

This block is the register front end of a descriptor-driven DMA controller. A 32-bit register bus reaches a row of identical channels. Each channel occupies its own 8 KiB address window. A channel keeps the pointer registers that the data mover uses to walk its descriptor chain. It also holds a configuration word, a command word and a stream-command word.

Each channel tracks a one-hot run state and an end-of-list flag. From these it builds a status word. It also keeps a raw interrupt vector. Engine pulses set bits in that vector, and software clears them through an acknowledge register. The vector is then masked and reduced to one interrupt line per channel.

Writes to the command and stream-command registers do not move any data. Each such write becomes a one-cycle strobe, which a separate data-mover engine acts on. That engine reports back through an end-of-list set pulse and the eol bit of its current data descriptor.

Top module: `dmac_csr_top`

## Requirements
- R1: Address bits 13 and up select the channel. Address bits 7:2 select the register inside the channel. An access to one channel leaves every register, interrupt line and strobe of every other channel unchanged.
- R2: The following word offsets store a full 32-bit write and read it back unchanged:
  - data pointer 0x00
  - saved data 0x58
  - saved buffer 0x5C
  - group 0x60
  - group-down 0x7C
  - command 0x80
  - configuration 0x84
  - interrupt mask 0x8C
  - stream command 0x9C
- R3: The channel state is one-hot: reset = 3'b001, stopped = 3'b010, running = 3'b100. It comes out of reset in the reset state.
- R4: A configuration write with bit 1 set moves the channel to stopped. A configuration write with bit 0 clear moves it to reset, and this rule wins over the stopped rule. A configuration write with bit 0 set and bit 1 clear leaves the state unchanged.
- R5: Status (0x88) reads back as follows:
  - bits 2:0 hold the state
  - bit 5 holds the end-of-list flag
  - bits 15:8 hold the stream-command source, which is 1
  - all other bits are 0

  After reset, status reads 0x101.
- R6: A write to acknowledge (0x90) clears each raw interrupt bit that is 1 in the written value. Acknowledge always reads as 0.
- R7: A one-cycle engine pulse on a raw interrupt bit sets that bit. If a set and an acknowledge hit the same bit in the same cycle, the bit stays set.
- R8: The raw interrupt vector reads at 0x94. The masked vector is raw AND mask and reads at 0x98. The channel interrupt line is the OR of the masked bits, so it follows any change to the mask at once.
- R9: A stream-command write uses only bits 9:0 of the value. When bits 8 and 6 are both set, it pulses the data-descriptor load strobe. When bit 5 is also set, it additionally pulses the start strobe, moves the state to running and clears end-of-list. Bit 9 pulses the context-descriptor load strobe.
- R10: A command write pulses the continue strobe only when all of the following hold:
  - configuration bit 0 is 1
  - configuration bit 1 is 0
  - the state is running
  - the descriptor eol input is high

  Otherwise it pulses nothing.
- R11: An access whose byte enables are not all four set is ignored, and it raises the error output for the following cycle.
- R12: An engine end-of-list pulse sets the end-of-list flag. A start clears the flag, but an end-of-list pulse in the same cycle wins.
- R13: Every strobe is high for exactly the one cycle that follows the clock edge accepting the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | Write when 1, read when 0 |
| byte_en_i | input | 4 | Byte enables; only 4'hF is accepted |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from the address |
| err_o | output | 1 | Narrow access seen in the previous cycle |
| intr_set_i | input | N_CH*IRQ_W | Raw interrupt set pulses, channel c at bits c*IRQ_W and up |
| eol_set_i | input | N_CH | End-of-list set pulse per channel |
| dscr_eol_i | input | N_CH | eol bit of each channel's current data descriptor |
| irq_o | output | N_CH | Interrupt line per channel |
| ld_data_o | output | N_CH | Data-descriptor load strobe |
| ld_ctx_o | output | N_CH | Context-descriptor load strobe |
| start_o | output | N_CH | Burst start strobe |
| cont_o | output | N_CH | Continue strobe |

## Verification
The assertions assume the following about the inputs:
- Engine interrupt and end-of-list inputs are single-cycle pulses.
- The bus presents at most one access per cycle, held stable across the accepting edge.

The stimulus changes every input only on the falling clock edge. It raises each engine pulse for exactly one cycle. It overlaps a set pulse with an acknowledge write only in the one case built to show which side wins. The continue checks change the descriptor eol input only between bus writes, never during one.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  localparam int unsigned IDX_W = 6;

  typedef enum logic [2:0] {
    ST_RST  = 3'b001,
    ST_STOP = 3'b010,
    ST_RUN  = 3'b100
  } ch_state_e;

  localparam logic [IDX_W-1:0] IX_DATA  = 6'h00;
  localparam logic [IDX_W-1:0] IX_SDATA = 6'h16;
  localparam logic [IDX_W-1:0] IX_SBUF  = 6'h17;
  localparam logic [IDX_W-1:0] IX_GRP   = 6'h18;
  localparam logic [IDX_W-1:0] IX_GDOWN = 6'h1F;
  localparam logic [IDX_W-1:0] IX_CMD   = 6'h20;
  localparam logic [IDX_W-1:0] IX_CFG   = 6'h21;
  localparam logic [IDX_W-1:0] IX_STAT  = 6'h22;
  localparam logic [IDX_W-1:0] IX_MASK  = 6'h23;
  localparam logic [IDX_W-1:0] IX_ACK   = 6'h24;
  localparam logic [IDX_W-1:0] IX_RAW   = 6'h25;
  localparam logic [IDX_W-1:0] IX_MSKD  = 6'h26;
  localparam logic [IDX_W-1:0] IX_SCMD  = 6'h27;

  localparam logic [9:0] SC_LOAD_D = 10'h140;
  localparam logic [9:0] SC_BURST  = 10'h020;
  localparam logic [9:0] SC_LOAD_C = 10'h200;

  localparam logic [7:0] SRC_ID = 8'h01;
endpackage

// File: rtl/dmac_addr_dec.sv
module dmac_addr_dec #(
  parameter int unsigned N_CH   = 2,
  parameter int unsigned CH_W   = 1,
  parameter int unsigned ADDR_W = 14
) (
  input  logic                     req_i,
  input  logic [3:0]               byte_en_i,
  input  logic [ADDR_W-1:0]        addr_i,
  output logic [N_CH-1:0]          ch_sel_o,
  output logic [dmac_pkg::IDX_W-1:0] idx_o,
  output logic                     narrow_o
);
  logic full;
  logic unused_addr;

  assign full        = req_i && (byte_en_i == 4'hF);
  assign narrow_o    = req_i && (byte_en_i != 4'hF);
  assign idx_o       = addr_i[7:2];
  assign unused_addr = ^{addr_i[12:8], addr_i[1:0]};

  for (genvar c = 0; c < N_CH; c++) begin : g_sel
    assign ch_sel_o[c] = full && (addr_i[ADDR_W-1:13] == CH_W'(c));
  end
endmodule

// File: rtl/dmac_chan.sv
module dmac_chan
  import dmac_pkg::*;
#(
  parameter int unsigned IRQ_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sel_i,
  input  logic             we_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [31:0]      wdata_i,
  input  logic [IRQ_W-1:0] intr_set_i,
  input  logic             eol_set_i,
  input  logic             dscr_eol_i,
  output logic [31:0]      rdata_o,
  output logic             irq_o,
  output logic             ld_data_o,
  output logic             ld_ctx_o,
  output logic             start_o,
  output logic             cont_o
);
  logic [31:0] r_data, r_sdata, r_sbuf, r_grp, r_gdown, r_cmd, r_cfg, r_mask, r_scmd;
  logic [IRQ_W-1:0] raw_q, masked, ack_vec;
  ch_state_e state_q;
  logic eol_q;

  logic wr, wr_cfg, wr_cmd, wr_scmd, wr_ack;
  logic [9:0] scmd_lo;
  logic do_ld_d, do_ld_c, do_start, do_cont;

  assign wr      = sel_i && we_i;
  assign wr_cfg  = wr && (idx_i == IX_CFG);
  assign wr_cmd  = wr && (idx_i == IX_CMD);
  assign wr_scmd = wr && (idx_i == IX_SCMD);
  assign wr_ack  = wr && (idx_i == IX_ACK);

  assign scmd_lo  = wdata_i[9:0];
  assign do_ld_d  = wr_scmd && ((scmd_lo & SC_LOAD_D) == SC_LOAD_D);
  assign do_start = do_ld_d && ((scmd_lo & SC_BURST) != '0);
  assign do_ld_c  = wr_scmd && ((scmd_lo & SC_LOAD_C) != '0);
  assign do_cont  = wr_cmd && r_cfg[0] && !r_cfg[1] && (state_q == ST_RUN) && dscr_eol_i;

  assign ack_vec = wr_ack ? wdata_i[IRQ_W-1:0] : '0;
  assign masked  = raw_q & r_mask[IRQ_W-1:0];
  assign irq_o   = |masked;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      r_data  <= '0; r_sdata <= '0; r_sbuf <= '0; r_grp  <= '0; r_gdown <= '0;
      r_cmd   <= '0; r_cfg   <= '0; r_mask <= '0; r_scmd <= '0;
    end else if (wr) begin
      case (idx_i)
        IX_DATA:  r_data  <= wdata_i;
        IX_SDATA: r_sdata <= wdata_i;
        IX_SBUF:  r_sbuf  <= wdata_i;
        IX_GRP:   r_grp   <= wdata_i;
        IX_GDOWN: r_gdown <= wdata_i;
        IX_CMD:   r_cmd   <= wdata_i;
        IX_CFG:   r_cfg   <= wdata_i;
        IX_MASK:  r_mask  <= wdata_i;
        IX_SCMD:  r_scmd  <= wdata_i;
        default:  ;
      endcase
    end
  end

  // Config rules: stop first, then the reset rule overrides it.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RST;
    end else if (wr_cfg) begin
      if (!wdata_i[0])     state_q <= ST_RST;
      else if (wdata_i[1]) state_q <= ST_STOP;
    end else if (do_start) begin
      state_q <= ST_RUN;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      eol_q     <= 1'b0;
      raw_q     <= '0;
      ld_data_o <= 1'b0;
      ld_ctx_o  <= 1'b0;
      start_o   <= 1'b0;
      cont_o    <= 1'b0;
    end else begin
      if (eol_set_i)     eol_q <= 1'b1;
      else if (do_start) eol_q <= 1'b0;
      raw_q     <= (raw_q & ~ack_vec) | intr_set_i;
      ld_data_o <= do_ld_d;
      ld_ctx_o  <= do_ld_c;
      start_o   <= do_start;
      cont_o    <= do_cont;
    end
  end

  always_comb begin
    case (idx_i)
      IX_DATA:  rdata_o = r_data;
      IX_SDATA: rdata_o = r_sdata;
      IX_SBUF:  rdata_o = r_sbuf;
      IX_GRP:   rdata_o = r_grp;
      IX_GDOWN: rdata_o = r_gdown;
      IX_CMD:   rdata_o = r_cmd;
      IX_CFG:   rdata_o = r_cfg;
      IX_STAT:  rdata_o = {16'h0, SRC_ID, 2'b00, eol_q, 2'b00, state_q};
      IX_MASK:  rdata_o = r_mask;
      IX_RAW:   rdata_o = 32'(raw_q);
      IX_MSKD:  rdata_o = 32'(masked);
      IX_SCMD:  rdata_o = r_scmd;
      default:  rdata_o = '0;
    endcase
  end

  p_state_onehot_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot(state_q));
  p_cfg_reset_wins_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_cfg && !wdata_i[0]) |=> (state_q == ST_RST));
  p_ack_clears_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ack |=> ((raw_q & $past(wdata_i[IRQ_W-1:0] & ~intr_set_i)) == '0));
  p_set_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|intr_set_i) |=> ((raw_q & $past(intr_set_i)) == $past(intr_set_i)));
  p_start_runs_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> (state_q == ST_RUN));
  p_cont_needs_run_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cont_o |-> ($past(state_q) == ST_RUN));
  p_strobe_single_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o);
endmodule

// File: rtl/dmac_csr_top.sv
module dmac_csr_top
  import dmac_pkg::*;
#(
  parameter int unsigned N_CH   = 2,
  parameter int unsigned IRQ_W  = 8,
  localparam int unsigned CH_W  = (N_CH > 1) ? $clog2(N_CH) : 1,
  localparam int unsigned ADDR_W = 13 + CH_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    req_i,
  input  logic                    we_i,
  input  logic [3:0]              byte_en_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [31:0]             wdata_i,
  output logic [31:0]             rdata_o,
  output logic                    err_o,
  input  logic [N_CH*IRQ_W-1:0]   intr_set_i,
  input  logic [N_CH-1:0]         eol_set_i,
  input  logic [N_CH-1:0]         dscr_eol_i,
  output logic [N_CH-1:0]         irq_o,
  output logic [N_CH-1:0]         ld_data_o,
  output logic [N_CH-1:0]         ld_ctx_o,
  output logic [N_CH-1:0]         start_o,
  output logic [N_CH-1:0]         cont_o
);
  logic [N_CH-1:0]  ch_sel;
  logic [IDX_W-1:0] idx;
  logic             narrow;
  logic [31:0]      ch_rd [N_CH];

  dmac_addr_dec #(.N_CH(N_CH), .CH_W(CH_W), .ADDR_W(ADDR_W)) u_dec (
    .req_i     (req_i),
    .byte_en_i (byte_en_i),
    .addr_i    (addr_i),
    .ch_sel_o  (ch_sel),
    .idx_o     (idx),
    .narrow_o  (narrow)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    dmac_chan #(.IRQ_W(IRQ_W)) u_chan (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .sel_i      (ch_sel[c]),
      .we_i       (we_i),
      .idx_i      (idx),
      .wdata_i    (wdata_i),
      .intr_set_i (intr_set_i[c*IRQ_W +: IRQ_W]),
      .eol_set_i  (eol_set_i[c]),
      .dscr_eol_i (dscr_eol_i[c]),
      .rdata_o    (ch_rd[c]),
      .irq_o      (irq_o[c]),
      .ld_data_o  (ld_data_o[c]),
      .ld_ctx_o   (ld_ctx_o[c]),
      .start_o    (start_o[c]),
      .cont_o     (cont_o[c])
    );
  end

  always_comb begin
    rdata_o = '0;
    for (int c = 0; c < N_CH; c++) begin
      if (ch_sel[c] && !we_i) rdata_o = rdata_o | ch_rd[c];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_o <= 1'b0;
    else         err_o <= narrow;
  end

  p_narrow_err_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && (byte_en_i != 4'hF)) |=> err_o);
  p_one_sel_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ch_sel));
endmodule

// File: tb/dmac_csr_top_bench.sv
module dmac_csr_top_bench;
  localparam int N_CH = 2;
  localparam int IRQ_W = 8;
  localparam int ADDR_W = 14;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [3:0] be = 4'hF;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic err;
  logic [N_CH*IRQ_W-1:0] intr_set = '0;
  logic [N_CH-1:0] eol_set = '0, dscr_eol = '0;
  logic [N_CH-1:0] irq, ld_data, ld_ctx, start, cont;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dmac_csr_top #(.N_CH(N_CH), .IRQ_W(IRQ_W)) u_dmac_csr_top (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .byte_en_i(be),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .err_o(err),
    .intr_set_i(intr_set), .eol_set_i(eol_set), .dscr_eol_i(dscr_eol),
    .irq_o(irq), .ld_data_o(ld_data), .ld_ctx_o(ld_ctx), .start_o(start),
    .cont_o(cont)
  );

  typedef struct packed {
    logic        wr;
    logic [15:0] adr;
    logic [31:0] dat;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 16'h0088, 32'h0,        32'h0000_0101, 8'd5},  // R5 R3 reset status
    '{1'b0, 16'h2088, 32'h0,        32'h0000_0101, 8'd5},
    '{1'b0, 16'h0094, 32'h0,        32'h0,         8'd8},
    '{1'b1, 16'h0000, 32'hDEAD_0000, 32'h0,        8'd2},  // R2
    '{1'b0, 16'h0000, 32'h0,        32'hDEAD_0000, 8'd2},
    '{1'b1, 16'h2058, 32'h1234_5678, 32'h0,        8'd1},  // R1
    '{1'b0, 16'h2058, 32'h0,        32'h1234_5678, 8'd1},
    '{1'b0, 16'h0058, 32'h0,        32'h0,         8'd1},
    '{1'b1, 16'h005C, 32'hA5A5_A5A5, 32'h0,        8'd2},
    '{1'b0, 16'h005C, 32'h0,        32'hA5A5_A5A5, 8'd2},
    '{1'b1, 16'h0060, 32'h1111_0000, 32'h0,        8'd2},
    '{1'b0, 16'h0060, 32'h0,        32'h1111_0000, 8'd2},
    '{1'b1, 16'h007C, 32'h0000_2222, 32'h0,        8'd2},
    '{1'b0, 16'h007C, 32'h0,        32'h0000_2222, 8'd2},
    '{1'b1, 16'h0084, 32'h0000_0001, 32'h0,        8'd4},  // R4 no change
    '{1'b0, 16'h0088, 32'h0,        32'h0000_0101, 8'd4},
    '{1'b1, 16'h0084, 32'h0000_0003, 32'h0,        8'd4},  // R4 stop
    '{1'b0, 16'h0088, 32'h0,        32'h0000_0102, 8'd4},
    '{1'b1, 16'h0084, 32'h0000_0002, 32'h0,        8'd4},  // R4 reset wins
    '{1'b0, 16'h0088, 32'h0,        32'h0000_0101, 8'd4},
    '{1'b0, 16'h0084, 32'h0,        32'h0000_0002, 8'd2},
    '{1'b1, 16'h008C, 32'h0000_000F, 32'h0,        8'd2},
    '{1'b0, 16'h008C, 32'h0,        32'h0000_000F, 8'd2},
    '{1'b0, 16'h0090, 32'h0,        32'h0,         8'd6}   // R6 reads 0
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [31:0] d, input logic [3:0] b = 4'hF);
    req = 1'b1; we = 1'b1; addr = a[ADDR_W-1:0]; wdata = d; be = b;
    @(negedge clk);
    req = 1'b0; we = 1'b0; be = 4'hF;
  endtask

  task automatic bus_read(input logic [15:0] a, output logic [31:0] d);
    req = 1'b1; we = 1'b0; addr = a[ADDR_W-1:0]; be = 4'hF;
    #1 d = rdata;
    req = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [15:0] a, input logic [31:0] exp);
    logic [31:0] d;
    bus_read(a, d);
    chk(tag, d, exp);
  endtask

  task automatic pulse_intr(input logic [N_CH*IRQ_W-1:0] v);
    intr_set = v;
    @(negedge clk);
    intr_set = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 R13 reset outputs
    chk("R3 irq after reset", 32'(irq), 32'h0);
    chk("R13 strobes after reset", 32'({ld_data, ld_ctx, start, cont}), 32'h0);
    chk("R11 err after reset", 32'(err), 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].wr) bus_write(VECS[i].adr, VECS[i].dat);
      else begin
        bus_read(VECS[i].adr, d);
        n_chk++;
        if (d !== VECS[i].exp) begin
          n_fail++;
          $display("FAIL R%0d vec %0d act=%h exp=%h", VECS[i].req, i, d, VECS[i].exp);
        end
        @(negedge clk);
      end
    end

    // R9 stream commands
    bus_write(16'h009C, 32'h160);
    chk("R9 ld_data on 0x160", 32'(ld_data), 32'h1);
    chk("R9 start on 0x160", 32'(start), 32'h1);
    chk("R9 no ld_ctx on 0x160", 32'(ld_ctx), 32'h0);
    rd_chk("R9 running, eol clear", 16'h0088, 32'h104);
    bus_write(16'h009C, 32'h100);
    chk("R13 R9 partial pattern no load", 32'({ld_data, start}), 32'h0);
    bus_write(16'h009C, 32'h200);
    chk("R9 ctx load", 32'({ld_ctx, ld_data}), 32'h4);
    @(negedge clk);
    chk("R13 strobe one cycle", 32'(ld_ctx), 32'h0);
    bus_write(16'h009C, 32'h1360);
    chk("R9 upper bits ignored", 32'({ld_data, ld_ctx, start}), 32'h15);
    rd_chk("R2 stream cmd readback", 16'h009C, 32'h1360);

    // R12 end-of-list flag
    eol_set = 2'b01;
    @(negedge clk);
    eol_set = '0;
    rd_chk("R12 eol set", 16'h0088, 32'h124);
    rd_chk("R1 other channel eol", 16'h2088, 32'h101);
    bus_write(16'h009C, 32'h160);
    rd_chk("R12 start clears eol", 16'h0088, 32'h104);

    // R10 continue
    bus_write(16'h0084, 32'h1);
    rd_chk("R4 enable keeps running", 16'h0088, 32'h104);
    dscr_eol = 2'b01;
    bus_write(16'h0080, 32'h1);
    chk("R10 continue fires", 32'(cont), 32'h1);
    dscr_eol = 2'b00;
    bus_write(16'h0080, 32'h1);
    chk("R10 no continue without eol", 32'(cont), 32'h0);
    dscr_eol = 2'b01;
    bus_write(16'h0084, 32'h3);
    bus_write(16'h0080, 32'h1);
    chk("R10 no continue when stopped", 32'(cont), 32'h0);
    rd_chk("R4 stopped", 16'h0088, 32'h102);
    dscr_eol = 2'b00;

    // R7 R8 R6 interrupts
    pulse_intr(16'h0003);
    rd_chk("R7 raw set", 16'h0094, 32'h3);
    rd_chk("R8 masked", 16'h0098, 32'h3);
    chk("R8 irq line", 32'(irq), 32'h1);
    bus_write(16'h0090, 32'h1);
    rd_chk("R6 ack clears bit0", 16'h0094, 32'h2);
    intr_set = 16'h0002;
    bus_write(16'h0090, 32'h2);
    intr_set = '0;
    rd_chk("R7 set wins over ack", 16'h0094, 32'h2);
    bus_write(16'h0090, 32'h2);
    rd_chk("R6 ack clears bit1", 16'h0094, 32'h0);
    chk("R8 irq low", 32'(irq), 32'h0);
    pulse_intr(16'h0010);
    chk("R8 masked off", 32'(irq), 32'h0);
    rd_chk("R8 masked value 0", 16'h0098, 32'h0);
    bus_write(16'h008C, 32'hFF);
    chk("R8 mask raises irq", 32'(irq), 32'h1);
    pulse_intr(16'h0100);
    rd_chk("R1 ch1 raw", 16'h2094, 32'h1);
    chk("R1 ch1 irq masked off", 32'(irq), 32'h1);
    bus_write(16'h0090, 32'h10);
    chk("R6 ack drops irq", 32'(irq), 32'h0);

    // R11 narrow access
    bus_write(16'h0000, 32'h0, 4'h3);
    chk("R11 err raised", 32'(err), 32'h1);
    rd_chk("R11 data unchanged", 16'h0000, 32'hDEAD_0000);
    @(negedge clk);
    chk("R11 err one cycle", 32'(err), 32'h0);

    finish_run();
  end
endmodule